// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

Two independent timer/counter units, each built from a low byte and a high byte, that advance either on a machine-cycle enable or on falling edges of an external count pin. A shared mode byte picks the width and behaviour of each unit: a 13-bit count whose low byte acts as a 5-bit prescaler, a full 16-bit count, an 8-bit count that reloads from the high byte, or a split arrangement in which unit 0 becomes two separate 8-bit counters.

A control nibble holds one run bit and one overflow flag per unit. A unit can also be gated by an external level, so that it counts only while that level is high. Software loads the count bytes, the mode byte and the control nibble through a simple one-cycle write port. Every overflow that belongs to unit 1 also produces a single-cycle pulse, which a serial bit-rate generator can use as its clock.

Top module: `dual_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all four count bytes, the mode byte and the control nibble read zero, and `baud_tick` is low.
- R2: A write with `wr_en` high updates the register chosen by `wr_sel` at the next clock edge. The selector codes are 0 for unit 0 low, 1 for unit 0 high, 2 for unit 1 low, 3 for unit 1 high, 4 for the mode byte and 5 for the control nibble. A write to either count byte of a unit holds that unit's count for that cycle, so the written value is exactly what is read back.
- R3: Each unit advances only when two conditions hold. Its run bit must be set (control bit 0 for unit 0, bit 1 for unit 1). Either its gate bit must be clear, or its `ext_gate` line must be high. The gate bit is mode bit 3 for unit 0 and mode bit 7 for unit 1.
- R4: Mode 0 (mode field 2'b00): when the low five bits of the low byte are all ones, an advance clears the low byte and increments the high byte. Otherwise the low byte increments. When the high byte wraps from 0xFF, the unit's flag is set.
- R5: Mode 1 (2'b01): the high and low bytes form a 16-bit count. A wrap from 0xFFFF to 0 sets the unit's flag.
- R6: Mode 2 (2'b10): only the low byte counts. An advance from 0xFF loads the low byte from the high byte and sets the unit's flag. The high byte never changes except by a write.
- R7: When unit 0's mode field is 2'b11, unit 0's low byte is an 8-bit counter that uses unit 0's run, gate and source bits, and its wrap sets flag 0. Unit 0's high byte increments on each `tick` while unit 1's run and gate conditions hold, and its wrap sets flag 1.
- R8: When unit 1's mode field (mode bits 5:4) is 2'b11, unit 1's count bytes hold their value.
- R9: When a unit's source bit is set (mode bit 2 for unit 0, bit 6 for unit 1), the unit ignores `tick`. It advances once for each high-to-low change on its `ext_cnt` line. Because the line passes through a two-stage synchronizer, a change sampled at one clock edge advances the count two edges later.
- R10: `baud_tick` is high for exactly the cycle after each clock edge at which a unit-1 overflow occurs, whether from unit 1 itself or from unit 0's high byte in split mode.
- R11: The control nibble reads {flag1, flag0, run1, run0}. A control write replaces all four bits, and it takes precedence over a flag being set by hardware on the same edge. Without such a write, a flag stays set once set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Machine-cycle enable for timer-source counting |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector for the write |
| wr_data | input | 8 | Write data |
| ext_cnt | input | 2 | External count pins, bit i for unit i |
| ext_gate | input | 2 | External gate levels, bit i for unit i |
| t0_lo | output | 8 | Unit 0 low byte |
| t0_hi | output | 8 | Unit 0 high byte |
| t1_lo | output | 8 | Unit 1 low byte |
| t1_hi | output | 8 | Unit 1 high byte |
| mode_q | output | 8 | Mode byte |
| ctrl_q | output | 4 | {flag1, flag0, run1, run0} |
| baud_tick | output | 1 | One-cycle unit-1 overflow pulse |

## Verification
The bench loads each count close to its wrap point. This exposes a mode 0 prescaler that carries at bit 8 instead of bit 5, a mode 2 that reloads with 0 instead of the high byte, and a 16-bit mode that raises the flag one count early. Split mode is driven with both run bits in every combination, so a design that ties unit 0's high byte to unit 0's run bit, or that sets flag 0 from it, shows wrong bytes or flags. Writes are placed on the very cycle of an overflow and on pin edges, which catches a count that takes precedence over a write, a flag set that defeats a control write, and a synchronizer that is one stage short.

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int PRE_BITS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [1:0] ext_cnt,
  input  logic [1:0] ext_gate,
  output logic [7:0] t0_lo,
  output logic [7:0] t0_hi,
  output logic [7:0] t1_lo,
  output logic [7:0] t1_hi,
  output logic [7:0] mode_q,
  output logic [3:0] ctrl_q,
  output logic       baud_tick
);
  localparam logic [7:0] PRE_MASK = 8'((1 << PRE_BITS) - 1);

  logic [7:0] lo_q [2];
  logic [7:0] hi_q [2];
  logic [7:0] lo_n [2];
  logic [7:0] hi_n [2];
  logic [7:0] mode_r;
  logic [1:0] run_r, flag_r, ovf, wr_lo, wr_hi;
  logic [1:0] sy1, sy2, sy3, fall;
  logic       baud_r, split, split_go, split_ovf, ovf1_any, wr_ctrl;

  assign fall     = sy3 & ~sy2;
  assign split    = (mode_r[1:0] == 2'b11);
  assign wr_lo    = {wr_en && wr_sel == 3'd2, wr_en && wr_sel == 3'd0};
  assign wr_hi    = {wr_en && wr_sel == 3'd3, wr_en && wr_sel == 3'd1};
  assign wr_ctrl  = wr_en && wr_sel == 3'd5;
  assign ovf1_any = ovf[1] | split_ovf;

  always_comb begin
    logic [1:0] md;
    logic       go, hold;
    for (int i = 0; i < 2; i++) begin
      md   = mode_r[4*i +: 2];
      go   = run_r[i] & (~mode_r[4*i+3] | ext_gate[i]) &
             (mode_r[4*i+2] ? fall[i] : tick);
      hold = wr_lo[i] | (wr_hi[i] & ~(i == 0 && split));
      lo_n[i] = lo_q[i];
      hi_n[i] = hi_q[i];
      ovf[i]  = 1'b0;
      if (go && !hold) begin
        case (md)
          2'b00: begin
            lo_n[i] = lo_q[i] + 8'd1;
            if ((lo_n[i] & PRE_MASK) == 8'd0) begin
              lo_n[i] = 8'd0;
              hi_n[i] = hi_q[i] + 8'd1;
              ovf[i]  = (hi_q[i] == 8'hFF);
            end
          end
          2'b01: begin
            {hi_n[i], lo_n[i]} = {hi_q[i], lo_q[i]} + 16'd1;
            ovf[i] = ({hi_q[i], lo_q[i]} == 16'hFFFF);
          end
          2'b10: begin
            if (lo_q[i] == 8'hFF) begin
              lo_n[i] = hi_q[i];
              ovf[i]  = 1'b1;
            end else begin
              lo_n[i] = lo_q[i] + 8'd1;
            end
          end
          default: begin
            if (i == 0) begin
              lo_n[i] = lo_q[i] + 8'd1;
              ovf[i]  = (lo_q[i] == 8'hFF);
            end
          end
        endcase
      end
    end
    split_go  = split & run_r[1] & (~mode_r[7] | ext_gate[1]) & tick & ~wr_hi[0];
    split_ovf = split_go & (hi_q[0] == 8'hFF);
    if (split_go) hi_n[0] = hi_q[0] + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        lo_q[i] <= 8'd0;
        hi_q[i] <= 8'd0;
      end
      mode_r <= 8'd0;
      run_r  <= 2'b00;
      flag_r <= 2'b00;
      baud_r <= 1'b0;
      sy1    <= 2'b00;
      sy2    <= 2'b00;
      sy3    <= 2'b00;
    end else begin
      sy1 <= ext_cnt;
      sy2 <= sy1;
      sy3 <= sy2;
      for (int i = 0; i < 2; i++) begin
        lo_q[i] <= wr_lo[i] ? wr_data : lo_n[i];
        hi_q[i] <= wr_hi[i] ? wr_data : hi_n[i];
      end
      if (wr_en && wr_sel == 3'd4) mode_r <= wr_data;
      if (wr_ctrl) begin
        run_r  <= wr_data[1:0];
        flag_r <= wr_data[3:2];
      end else begin
        flag_r <= flag_r | {ovf1_any, ovf[0]};
      end
      baud_r <= ovf1_any;
    end
  end

  assign t0_lo     = lo_q[0];
  assign t0_hi     = hi_q[0];
  assign t1_lo     = lo_q[1];
  assign t1_hi     = hi_q[1];
  assign mode_q    = mode_r;
  assign ctrl_q    = {flag_r, run_r};
  assign baud_tick = baud_r;
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] t0_lo,
  input logic [7:0] t0_hi,
  input logic [7:0] t1_lo,
  input logic [7:0] t1_hi,
  input logic [7:0] mode_q,
  input logic [3:0] ctrl_q,
  input logic       baud_tick
);
  // R2
  wr_lo0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=> (t0_lo == $past(wr_data)));

  // R3
  t0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !(wr_en && wr_sel == 3'd0)) |=> $stable(t0_lo));

  // R6
  reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b10 && !(wr_en && wr_sel == 3'd1)) |=> $stable(t0_hi));

  // R7
  split_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b11 && !ctrl_q[1] && !(wr_en && wr_sel == 3'd1)) |=> $stable(t0_hi));

  // R8
  t1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[5:4] == 2'b11 && !(wr_en && (wr_sel == 3'd2 || wr_sel == 3'd3)))
      |=> ($stable(t1_lo) && $stable(t1_hi)));

  // R10
  baud_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && !$past(wr_en && wr_sel == 3'd5)) |-> ctrl_q[3]);
endmodule

bind dual_timer dual_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .t0_lo(t0_lo), .t0_hi(t0_hi), .t1_lo(t1_lo), .t1_hi(t1_hi),
  .mode_q(mode_q), .ctrl_q(ctrl_q), .baud_tick(baud_tick)
);

// File: tb/sim_dual_timer.sv
module sim_dual_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [2:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] ext_cnt = 0, ext_gate = 0;
  logic [7:0] t0_lo, t0_hi, t1_lo, t1_hi, mode_q;
  logic [3:0] ctrl_q;
  logic       baud_tick;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string cur_tag = "";

  logic [7:0] m_lo [2];
  logic [7:0] m_hi [2];
  logic [7:0] m_mode;
  logic [1:0] m_run, m_flag, m_p1, m_p2, m_p3;
  logic       m_baud;

  dual_timer u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %02h expected %02h", tag, what, got, exp);
    end
  endtask

  function automatic string mtag(input logic [1:0] md, input bit unit1);
    if (cur_tag != "") return cur_tag;
    case (md)
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return unit1 ? "R8" : "R7";
    endcase
  endfunction

  task automatic model_step();
    logic [1:0] fl, ov;
    logic sov, spl, act, hold;
    fl  = m_p3 & ~m_p2;
    ov  = 0;
    sov = 0;
    spl = (m_mode[1:0] == 2'b11);
    for (int i = 0; i < 2; i++) begin
      act  = m_run[i] && (!m_mode[4*i+3] || ext_gate[i]) && (m_mode[4*i+2] ? fl[i] : tick);
      hold = wr_en && (wr_sel == 3'(2*i) || (wr_sel == 3'(2*i+1) && !(i == 0 && spl)));
      if (act && !hold) begin
        case (m_mode[4*i +: 2])
          2'b00: if (m_lo[i][4:0] == 5'h1f) begin
                   m_lo[i] = 0; m_hi[i]++;
                   if (m_hi[i] == 0) ov[i] = 1;
                 end else m_lo[i]++;
          2'b01: begin
                   m_lo[i]++;
                   if (m_lo[i] == 0) begin m_hi[i]++; if (m_hi[i] == 0) ov[i] = 1; end
                 end
          2'b10: if (m_lo[i] == 8'hFF) begin m_lo[i] = m_hi[i]; ov[i] = 1; end
                 else m_lo[i]++;
          default: if (i == 0) begin m_lo[i]++; if (m_lo[i] == 0) ov[i] = 1; end
        endcase
      end
    end
    if (spl && m_run[1] && (!m_mode[7] || ext_gate[1]) && tick && !(wr_en && wr_sel == 3'd1)) begin
      m_hi[0]++;
      if (m_hi[0] == 0) sov = 1;
    end
    if (wr_en) begin
      case (wr_sel)
        3'd0: m_lo[0] = wr_data;
        3'd1: m_hi[0] = wr_data;
        3'd2: m_lo[1] = wr_data;
        3'd3: m_hi[1] = wr_data;
        3'd4: m_mode  = wr_data;
        default: ;
      endcase
    end
    if (wr_en && wr_sel == 3'd5) begin
      m_run = wr_data[1:0]; m_flag = wr_data[3:2];
    end else m_flag = m_flag | {ov[1] | sov, ov[0]};
    m_baud = ov[1] | sov;
    m_p3 = m_p2; m_p2 = m_p1; m_p1 = ext_cnt;
  endtask

  task automatic compare();
    chk(mtag(m_mode[1:0], 0), "t0_lo", t0_lo, m_lo[0]);
    chk(mtag(m_mode[1:0], 0), "t0_hi", t0_hi, m_hi[0]);
    chk(mtag(m_mode[5:4], 1), "t1_lo", t1_lo, m_lo[1]);
    chk(mtag(m_mode[5:4], 1), "t1_hi", t1_hi, m_hi[1]);
    chk(cur_tag != "" ? cur_tag : "R2", "mode", mode_q, m_mode);
    chk(cur_tag != "" ? cur_tag : "R11", "ctrl", {4'h0, ctrl_q}, {4'h0, m_flag, m_run});
    chk(cur_tag != "" ? cur_tag : "R10", "baud", {7'h0, baud_tick}, {7'h0, m_baud});
  endtask

  task automatic cycle(input logic tk, input logic we, input logic [2:0] sel,
                       input logic [7:0] d, input logic [1:0] cp, input logic [1:0] gp);
    tick = tk; wr_en = we; wr_sel = sel; wr_data = d; ext_cnt = cp; ext_gate = gp;
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    cycle(1'b0, 1'b1, sel, d, ext_cnt, ext_gate);
  endtask

  task automatic run_ticks(input int n);
    for (int k = 0; k < n; k++) cycle(1'b1, 1'b0, 3'd0, 8'd0, ext_cnt, ext_gate);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 2; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
    m_mode = 0; m_run = 0; m_flag = 0; m_baud = 0; m_p1 = 0; m_p2 = 0; m_p3 = 0;
    repeat (3) @(negedge clk);
    // R1 state during reset
    chk("R1", "t0_lo", t0_lo, 0); chk("R1", "t0_hi", t0_hi, 0);
    chk("R1", "t1_lo", t1_lo, 0); chk("R1", "t1_hi", t1_hi, 0);
    chk("R1", "mode", mode_q, 0); chk("R1", "ctrl", {4'h0, ctrl_q}, 0);
    chk("R1", "baud", {7'h0, baud_tick}, 0);
    rst_n = 1;
    cur_tag = "R1";
    cycle(1'b1, 1'b0, 3'd0, 8'd0, 2'b00, 2'b00);

    // R2 writes to every register, then a write against a running count
    cur_tag = "R2";
    wr(3'd0, 8'h12); wr(3'd1, 8'h34); wr(3'd2, 8'h56); wr(3'd3, 8'h78);
    wr(3'd4, 8'h11); wr(3'd5, 8'h03);
    cycle(1'b1, 1'b1, 3'd0, 8'hA5, 2'b00, 2'b00);
    cycle(1'b1, 1'b1, 3'd3, 8'h5A, 2'b00, 2'b00);
    wr(3'd5, 8'h00);

    // R4 prescaled 13-bit wrap
    cur_tag = "";
    wr(3'd4, 8'h00); wr(3'd0, 8'h1E); wr(3'd1, 8'hFF); wr(3'd5, 8'h01);
    run_ticks(3);
    wr(3'd0, 8'hE5); run_ticks(2);
    // R5 16-bit wrap
    wr(3'd4, 8'h01); wr(3'd0, 8'hFE); wr(3'd1, 8'hFF); wr(3'd5, 8'h01);
    run_ticks(3);
    // R6 reload from the high byte
    wr(3'd4, 8'h02); wr(3'd1, 8'hFD); wr(3'd0, 8'hFE); wr(3'd5, 8'h01);
    run_ticks(6);
    // R7 split mode, R10 pulse from the high byte
    wr(3'd4, 8'h03); wr(3'd0, 8'hFF); wr(3'd1, 8'hFE); wr(3'd5, 8'h03);
    run_ticks(4);
    wr(3'd5, 8'h02); run_ticks(3);
    // R8 unit 1 halted
    wr(3'd4, 8'h30); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd5, 8'h02);
    run_ticks(4);
    // R10 repeated pulses from unit 1 in reload mode, R11 write on the overflow edge
    wr(3'd4, 8'h20); wr(3'd3, 8'hFE); wr(3'd2, 8'hFE); wr(3'd5, 8'h02);
    run_ticks(5);
    cycle(1'b1, 1'b1, 3'd5, 8'h02, 2'b00, 2'b00);
    run_ticks(2);

    // R3 gate behaviour
    cur_tag = "R3";
    wr(3'd4, 8'h09); wr(3'd5, 8'h01);
    for (int k = 0; k < 12; k++) cycle(1'b1, 1'b0, 3'd0, 8'd0, 2'b00, {1'b0, k[1]});
    wr(3'd5, 8'h00);
    for (int k = 0; k < 4; k++) cycle(1'b1, 1'b0, 3'd0, 8'd0, 2'b00, 2'b11);

    // R9 external count source
    cur_tag = "R9";
    wr(3'd4, 8'h45); wr(3'd5, 8'h03);
    for (int k = 0; k < 24; k++)
      cycle(k[0], 1'b0, 3'd0, 8'd0, {k[2], k[1]}, 2'b00);
    for (int k = 0; k < 16; k++)
      cycle(1'b1, 1'b0, 3'd0, 8'd0, 2'b11, 2'b00);

    // random mix
    cur_tag = "";
    for (int k = 0; k < 6000; k++) begin
      logic [2:0] sel;
      logic [7:0] d;
      logic we;
      we  = ($urandom_range(0, 9) == 0);
      sel = 3'($urandom_range(0, 5));
      d   = ($urandom_range(0, 2) == 0) ? 8'(8'hF8 | 8'($urandom_range(0, 7))) : 8'($urandom);
      if (sel == 3'd5) d = {4'h0, 2'($urandom_range(0, 3)) & 2'b01, 2'($urandom)} ;
      cycle(1'($urandom_range(0, 3) != 0), we, sel, d, 2'($urandom), 2'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule